// File: doc/BRIEF.md
# Power-Management Command Port with SMI Request

This block sits behind a host I/O window and decodes single-byte writes to a power-management command port. Two reserved command codes are consumed locally: one turns the ACPI mode on by setting the SCI-enable bit of the PM1 control register, the other turns it off by clearing that bit. Every other code is treated as a request for system-management service. It produces a one-clock SMI pulse, but only while the SMI-enable bit of the SMI control configuration byte is set.

A second I/O port next to the command port holds a scratch status byte that software can read and write. A byte-addressed configuration bus reaches a small bank of four SMI-control bytes. Reads on both buses return data one cycle after the request. A strap input tells the block whether system-management mode is available. When it is not, the SMI control byte comes out of reset with its enable bit already set, so the SMM machinery appears initialised. The PM1 control value is driven on an output so that the SCI-enable state can be observed directly.

Top module: `apm_smi_port`

## Requirements
- R1: An I/O write of 0xF1 to port 0xB2 sets pm1_ctrl bit 0 (SCI enable), visible from the first clock edge after the write.
- R2: An I/O write of 0xF0 to port 0xB2 clears pm1_ctrl bit 0, visible from the first clock edge after the write.
- R3: Writes of 0xF0 or 0xF1 to port 0xB2 never raise smi_pulse, whatever the SMI-enable bit holds.
- R4: A write to port 0xB2 of any value other than 0xF0 or 0xF1, while bit 1 of configuration byte 0x5B is set, raises smi_pulse for exactly the one cycle after the write's clock edge.
- R5: smi_pulse stays low after a command write while bit 1 of byte 0x5B is clear, and in every cycle that follows no command write.
- R6: On reset, pm1_ctrl and smi_pulse are 0, configuration bytes 0x58 to 0x5A read 0, and byte 0x5B reads 0x00 with smm_avail high or 0x02 with smm_avail low. The command and status ports read 0.
- R7: A configuration write to 0x58 to 0x5B stores the byte. cfg_rdata shows the addressed byte one cycle after cfg_rd, and holds otherwise. A read in the same cycle as a write to the same byte returns the old value. Addresses outside 0x58 to 0x5B read 0, and writes to them are ignored.
- R8: Port 0xB3 is a read/write status byte, and reading port 0xB2 returns the last command byte written. Reads of any other I/O address return 0. io_rdata shows data one cycle after io_rd and holds otherwise.
- R9: When a command write and a configuration write to byte 0x5B fall in the same cycle, the SMI decision uses the value byte 0x5B held before that cycle's edge.
- R10: I/O writes to addresses other than 0xB2 raise no SMI and leave pm1_ctrl unchanged. So do command values other than 0xF0 and 0xF1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_avail | input | 1 | Strap: system-management mode present; sampled during reset |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host I/O write byte |
| io_rdata | output | 8 | Host I/O read byte, one cycle after io_rd |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_rd | input | 1 | Configuration read request |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte, one cycle after cfg_rd |
| pm1_ctrl | output | 16 | PM1 control value; bit 0 is SCI enable |
| smi_pulse | output | 1 | One-cycle SMI request |

## Verification
The two functions that can meet in one cycle are a command-port write and a configuration write that changes the SMI-enable bit of byte 0x5B. Directed cycles cover both directions: enable cleared while a plain command arrives (pulse expected), and enable set while a plain command arrives (no pulse expected). The random phase then drives both buses at once many times. A bench model holds the pre-edge value of byte 0x5B and predicts the pulse from it, and any miscompare in a cycle with such a clash is reported against R9.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_ACPI_ON  = 2'd1,
    CMD_ACPI_OFF = 2'd2,
    CMD_SMI      = 2'd3
  } apm_cmd_e;

  localparam logic [7:0] ACPI_ON_CODE  = 8'hF1;
  localparam logic [7:0] ACPI_OFF_CODE = 8'hF0;

  // Sort a command byte into the action it asks for.
  function automatic apm_cmd_e classify_cmd(input logic [7:0] code);
    if (code == ACPI_ON_CODE)       return CMD_ACPI_ON;
    else if (code == ACPI_OFF_CODE) return CMD_ACPI_OFF;
    else                            return CMD_SMI;
  endfunction

  // Reset image of one SMI-control byte. Only the SMI byte differs,
  // and only when SMM is absent (enable bit pre-set).
  function automatic logic [7:0] cfg_reset_byte(input int unsigned idx,
                                                input int unsigned smi_idx,
                                                input int unsigned smi_bit,
                                                input logic        smm_avail);
    logic [7:0] v;
    v = '0;
    if (idx == smi_idx && !smm_avail) v[smi_bit[2:0]] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank
  import apm_smi_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned BASE    = 'h58,
  parameter int unsigned COUNT   = 4,
  parameter int unsigned SMI_IDX = 3,
  parameter int unsigned SMI_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smm_avail,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  output logic          smi_gate
);

  localparam int unsigned   IW      = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [AW-1:0] BASE_A  = AW'(BASE);
  localparam logic [AW-1:0] COUNT_A = AW'(COUNT);

  logic [7:0]    bytes_q [COUNT];
  logic [AW-1:0] offset;
  logic          in_range;
  logic [IW-1:0] idx;

  assign offset   = cfg_addr - BASE_A;
  assign in_range = (cfg_addr >= BASE_A) && (offset < COUNT_A);
  assign idx      = offset[IW-1:0];

  for (genvar g = 0; g < COUNT; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        bytes_q[g] <= cfg_reset_byte(g, SMI_IDX, SMI_BIT, smm_avail);
      else if (cfg_wr && in_range && idx == IW'(g))
        bytes_q[g] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_rdata <= '0;
    else if (cfg_rd)
      cfg_rdata <= in_range ? bytes_q[idx] : 8'h00;
  end

  assign smi_gate = bytes_q[SMI_IDX][SMI_BIT];

  AST_CFG_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !in_range) |=> (cfg_rdata == 8'h00)); // R7

  AST_CFG_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd && !$past(!rst_n)) |=> $stable(cfg_rdata)); // R7

endmodule

// File: rtl/apm_io_port.sv
module apm_io_port #(
  parameter int unsigned AW       = 16,
  parameter int unsigned CMD_PORT = 'hB2,
  parameter int unsigned STS_PORT = 'hB3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          cmd_stb,
  output logic [7:0]    cmd_byte
);

  localparam logic [AW-1:0] CMD_A = AW'(CMD_PORT);
  localparam logic [AW-1:0] STS_A = AW'(STS_PORT);

  logic [7:0] last_cmd_q;
  logic [7:0] status_q;
  logic       sel_cmd;
  logic       sel_sts;

  assign sel_cmd  = (io_addr == CMD_A);
  assign sel_sts  = (io_addr == STS_A);
  assign cmd_stb  = io_wr && sel_cmd;
  assign cmd_byte = io_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_cmd_q <= '0;
      status_q   <= '0;
    end else if (io_wr) begin
      if (sel_cmd) last_cmd_q <= io_wdata;
      if (sel_sts) status_q   <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      io_rdata <= '0;
    else if (io_rd)
      io_rdata <= sel_cmd ? last_cmd_q : (sel_sts ? status_q : 8'h00);
  end

  AST_IO_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !sel_cmd && !sel_sts) |=> (io_rdata == 8'h00)); // R8

endmodule

// File: rtl/apm_cmd_engine.sv
module apm_cmd_engine
  import apm_smi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb,
  input  logic [7:0] cmd_byte,
  input  logic       smi_gate,
  output apm_cmd_e   cmd_kind,
  output logic       sci_en,
  output logic       smi_pulse
);

  logic is_acpi_code;

  assign cmd_kind     = cmd_stb ? classify_cmd(cmd_byte) : CMD_NONE;
  assign is_acpi_code = (cmd_byte == ACPI_ON_CODE) || (cmd_byte == ACPI_OFF_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_en    <= 1'b0;
      smi_pulse <= 1'b0;
    end else begin
      smi_pulse <= (cmd_kind == CMD_SMI) && smi_gate;
      case (cmd_kind)
        CMD_ACPI_ON:  sci_en <= 1'b1;
        CMD_ACPI_OFF: sci_en <= 1'b0;
        default:      sci_en <= sci_en;
      endcase
    end
  end

  AST_ACPI_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_byte == 8'hF1) |=> sci_en); // R1

  AST_ACPI_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_byte == 8'hF0) |=> !sci_en); // R2

  AST_ACPI_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && is_acpi_code) |=> !smi_pulse); // R3

  AST_SMI_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !is_acpi_code && smi_gate) |=> smi_pulse); // R4

  AST_SMI_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && smi_gate) |=> !smi_pulse); // R5

  AST_SCI_ONLY_BY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_stb && is_acpi_code) && !$past(!rst_n)) |=> $stable(sci_en)); // R10

endmodule

// File: rtl/apm_smi_port.sv
module apm_smi_port
  import apm_smi_pkg::*;
#(
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned CMD_PORT = 'hB2,
  parameter int unsigned STS_PORT = 'hB3,
  parameter int unsigned CFG_BASE = 'h58,
  parameter int unsigned CFG_CNT  = 4,
  parameter int unsigned SMI_IDX  = 3,
  parameter int unsigned SMI_BIT  = 1,
  parameter int unsigned PM1_W    = 16,
  parameter int unsigned SCI_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smm_avail,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [PM1_W-1:0]  pm1_ctrl,
  output logic              smi_pulse
);

  localparam logic [IO_AW-1:0] CMD_A = IO_AW'(CMD_PORT);

  logic       cmd_stb;
  logic [7:0] cmd_byte;
  logic       smi_gate;
  logic       sci_en;
  apm_cmd_e   cmd_kind;

  apm_io_port #(
    .AW(IO_AW), .CMD_PORT(CMD_PORT), .STS_PORT(STS_PORT)
  ) u_io (
    .clk(clk), .rst_n(rst_n),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte)
  );

  apm_cfg_bank #(
    .AW(CFG_AW), .BASE(CFG_BASE), .COUNT(CFG_CNT),
    .SMI_IDX(SMI_IDX), .SMI_BIT(SMI_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .smm_avail(smm_avail),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smi_gate(smi_gate)
  );

  apm_cmd_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .smi_gate(smi_gate),
    .cmd_kind(cmd_kind), .sci_en(sci_en), .smi_pulse(smi_pulse)
  );

  always_comb begin
    pm1_ctrl          = '0;
    pm1_ctrl[SCI_BIT] = sci_en;
  end

  AST_FOREIGN_PORT_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != CMD_A) |=> !smi_pulse); // R10

  AST_NO_KIND_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr) |-> (cmd_kind == CMD_NONE)); // R10

endmodule

// File: tb/apm_smi_port_tb_top.sv
module apm_smi_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smm_avail = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] pm1_ctrl;
  logic        smi_pulse;

  always #5 clk = ~clk;

  apm_smi_port dut_i (
    .clk(clk), .rst_n(rst_n), .smm_avail(smm_avail),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm1_ctrl(pm1_ctrl), .smi_pulse(smi_pulse)
  );

  // Bench model state
  logic [7:0] m_cfg [4];
  logic       m_sci;
  logic [7:0] m_cmd, m_sts, m_iord, m_cfgrd;
  int vecs = 0;
  int errs = 0;

  // 0 = ACPI on, 1 = ACPI off, 2 = plain command
  function automatic int kind_of(input logic [7:0] b);
    if (b == 8'hF1) return 0;
    if (b == 8'hF0) return 1;
    return 2;
  endfunction

  function automatic logic [7:0] rst_image(input int idx, input logic smm);
    return (idx == 3 && !smm) ? 8'h02 : 8'h00;
  endfunction

  function automatic bit cfg_hit(input logic [7:0] a);
    return (a >= 8'h58) && (a <= 8'h5B);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called just after a negedge; leaves just after the next negedge.
  task automatic cycle(input logic iw, input logic ir, input logic [15:0] ia,
                       input logic [7:0] iwd, input logic cw, input logic cr,
                       input logic [7:0] ca, input logic [7:0] cwd);
    logic       e_smi, e_sci;
    logic [7:0] e_io, e_cf;
    bool_t_dummy: begin end
    io_wr = iw; io_rd = ir; io_addr = ia; io_wdata = iwd;
    cfg_wr = cw; cfg_rd = cr; cfg_addr = ca; cfg_wdata = cwd;
    e_smi = iw && ia == 16'hB2 && kind_of(iwd) == 2 && m_cfg[3][1];
    e_sci = m_sci;
    if (iw && ia == 16'hB2 && kind_of(iwd) == 0) e_sci = 1'b1;
    if (iw && ia == 16'hB2 && kind_of(iwd) == 1) e_sci = 1'b0;
    e_io = m_iord;
    if (ir) e_io = (ia == 16'hB2) ? m_cmd : ((ia == 16'hB3) ? m_sts : 8'h00);
    e_cf = m_cfgrd;
    if (cr) e_cf = cfg_hit(ca) ? m_cfg[ca - 8'h58] : 8'h00;
    @(posedge clk);
    #2;
    if (iw && ia == 16'hB2 && kind_of(iwd) != 2) chk("R3", "smi", 16'(smi_pulse), 16'(e_smi));
    else if (cw && ca == 8'h5B && iw && ia == 16'hB2) chk("R9", "smi", 16'(smi_pulse), 16'(e_smi));
    else if (e_smi) chk("R4", "smi", 16'(smi_pulse), 16'(e_smi));
    else if (iw && ia != 16'hB2) chk("R10", "smi", 16'(smi_pulse), 16'(e_smi));
    else chk("R5", "smi", 16'(smi_pulse), 16'(e_smi));
    if (iw && ia == 16'hB2 && kind_of(iwd) == 0) chk("R1", "pm1", pm1_ctrl, {15'b0, e_sci});
    else if (iw && ia == 16'hB2 && kind_of(iwd) == 1) chk("R2", "pm1", pm1_ctrl, {15'b0, e_sci});
    else chk("R10", "pm1", pm1_ctrl, {15'b0, e_sci});
    chk("R8", "io_rdata", 16'(io_rdata), 16'(e_io));
    chk("R7", "cfg_rdata", 16'(cfg_rdata), 16'(e_cf));
    m_sci = e_sci; m_iord = e_io; m_cfgrd = e_cf;
    if (iw && ia == 16'hB2) m_cmd = iwd;
    if (iw && ia == 16'hB3) m_sts = iwd;
    if (cw && cfg_hit(ca)) m_cfg[ca - 8'h58] = cwd;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 8'h0, 8'h0);
  endtask

  task automatic do_reset(input logic smm);
    @(negedge clk);
    rst_n = 1'b0; smm_avail = smm;
    io_wr = 1'b0; io_rd = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) m_cfg[i] = rst_image(i, smm);
    m_sci = 1'b0; m_cmd = 8'h00; m_sts = 8'h00; m_iord = 8'h00; m_cfgrd = 8'h00;
    #1;
    chk("R6", "pm1 after reset", pm1_ctrl, 16'h0000);
    chk("R6", "smi after reset", 16'(smi_pulse), 16'h0000);
    for (int i = 0; i < 4; i++) begin
      cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 8'h58 + 8'(i), 8'h0);
      chk("R6", "cfg reset image", 16'(cfg_rdata), 16'(rst_image(i, smm)));
    end
    cycle(1'b0, 1'b1, 16'hB2, 8'h0, 1'b0, 1'b0, 8'h0, 8'h0);
    chk("R6", "cmd port after reset", 16'(io_rdata), 16'h0000);
    cycle(1'b0, 1'b1, 16'hB3, 8'h0, 1'b0, 1'b0, 8'h0, 8'h0);
    chk("R6", "status after reset", 16'(io_rdata), 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);            // R6: SMM absent, 0x5B = 0x02
    do_reset(1'b1);            // R6: SMM present, 0x5B = 0x00

    // R5: plain command with gate clear
    cycle(1'b1, 1'b0, 16'hB2, 8'h55, 1'b0, 1'b0, 8'h0, 8'h0);
    // R4: enable gate, plain command pulses for one cycle
    cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 8'h5B, 8'h02);
    cycle(1'b1, 1'b0, 16'hB2, 8'h55, 1'b0, 1'b0, 8'h0, 8'h0);
    idle();
    // R1/R3 and R2/R3 with gate set
    cycle(1'b1, 1'b0, 16'hB2, 8'hF1, 1'b0, 1'b0, 8'h0, 8'h0);
    cycle(1'b1, 1'b0, 16'hB2, 8'hF0, 1'b0, 1'b0, 8'h0, 8'h0);
    cycle(1'b1, 1'b0, 16'hB2, 8'hF1, 1'b0, 1'b0, 8'h0, 8'h0);
    // R10: foreign port write
    cycle(1'b1, 1'b0, 16'hB1, 8'h55, 1'b0, 1'b0, 8'h0, 8'h0);
    cycle(1'b1, 1'b0, 16'hB3, 8'hF0, 1'b0, 1'b0, 8'h0, 8'h0);
    // R8: status and command readback, other port reads zero
    cycle(1'b0, 1'b1, 16'hB3, 8'h0, 1'b0, 1'b0, 8'h0, 8'h0);
    cycle(1'b0, 1'b1, 16'hB2, 8'h0, 1'b0, 1'b0, 8'h0, 8'h0);
    cycle(1'b0, 1'b1, 16'hB4, 8'h0, 1'b0, 1'b0, 8'h0, 8'h0);
    // R7: out-of-range write ignored, read returns zero; same-cycle read sees old
    cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 8'h57, 8'hAA);
    cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 8'h57, 8'h0);
    cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 8'h59, 8'h3C);
    cycle(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 8'h59, 8'h0);
    // R9: gate change in the same cycle as a command
    cycle(1'b1, 1'b0, 16'hB2, 8'h66, 1'b1, 1'b0, 8'h5B, 8'h00);
    cycle(1'b1, 1'b0, 16'hB2, 8'h66, 1'b1, 1'b0, 8'h5B, 8'h02);
    cycle(1'b1, 1'b0, 16'hB2, 8'h66, 1'b0, 1'b0, 8'h0, 8'h0);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0]  d, ca;
      case ($urandom % 4)
        0: a = 16'hB2; 1: a = 16'hB2; 2: a = 16'hB3; default: a = 16'hB1;
      endcase
      case ($urandom % 4)
        0: d = 8'hF0; 1: d = 8'hF1; 2: d = 8'h55; default: d = 8'($urandom);
      endcase
      ca = ($urandom % 2 == 0) ? 8'h5B : 8'h56 + 8'($urandom % 8);
      cycle(($urandom % 2) == 0, ($urandom % 3) == 0, a, d,
            ($urandom % 3) == 0, ($urandom % 3) == 0, ca, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule